// File: doc/BRIEF.md
# USB OUT Endpoint Control and Status Register

This block holds the control and status state of one USB OUT endpoint. It sits between the packet receiver on the USB function side and a microcontroller register bus. For each completed OUT packet the receiver reports one strobe with qualifiers: CRC or bit-stuffing error, packet longer than the maximum size, and protocol violation. One cycle later the block returns a verdict that says whether to keep the data, answer NAK, answer STALL or drop the packet without a handshake. At the same time it updates its flags.

The microcontroller reads one 8-bit register. It clears event flags by writing 1 to them, and it writes the stall-request and isochronous-mode bits directly. A separate single-cycle flush input empties the endpoint and clears the packet-ready flag. The block answers a flush with a one-cycle pulse toward the FIFO.

In isochronous mode the block behaves differently. A packet that arrives while the previous one is still unread is dropped and raises an overrun flag. A corrupted packet is still delivered, and it raises a data-error flag. In bulk/interrupt mode a waiting packet causes NAK, and a corrupted packet is ignored.

Top module: `usb_out_ep_csr`

## Requirements
- R1: After reset the register reads 0x00, `stall_req` is 0 and `dec_valid` is 0.
- R2: While `bus_addr` equals `CSR_ADDR` (default 0x8B), `bus_rdata` returns the register: bit0 packet-ready, bit1 overrun, bit2 send-stall, bit3 force-stall, bit4 iso, bit5 data-error, bits 7:6 zero. Any other address reads 0.
- R3: A write to `CSR_ADDR` clears each of bits 0, 1, 3 and 5 whose write-data bit is 1. A 0 leaves the bit unchanged. A write to any other address changes nothing.
- R4: A write to `CSR_ADDR` loads bits 2 (send-stall) and 4 (iso) from the write data. `stall_req` always equals the send-stall bit.
- R5: Every `rx_end` gives `dec_valid` high for exactly the next cycle, with `dec_code` encoded as 0 accept, 1 NAK, 2 STALL, 3 drop. A verdict is based on the flag values held before that edge.
- R6: In bulk/interrupt mode (iso=0), a packet without error that arrives while packet-ready is 1 gets NAK, and no flag changes. The same packet with packet-ready at 0 is accepted and sets packet-ready.
- R7: In bulk/interrupt mode, a packet with `rx_crc_err` and no length or protocol fault is dropped, and no flag changes.
- R8: In iso mode, a packet that arrives while packet-ready is 1 is dropped and sets overrun. Overrun and data-error are never set while iso=0.
- R9: In iso mode, a packet with `rx_crc_err` that arrives while packet-ready is 0 is accepted and sets both packet-ready and data-error.
- R10: With send-stall at 0, a packet with `rx_too_long` or `rx_proto_err` gets STALL and sets force-stall, whatever the mode.
- R11: While send-stall is 1, every packet gets STALL and no event flag changes.
- R12: `ep_flush` clears packet-ready, and `fifo_flush` pulses high in the following cycle.
- R13: When a hardware set and a clear (write-1 or flush) hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | MCU register address |
| bus_wr | input | 1 | MCU write strobe |
| bus_wdata | input | DATA_W | MCU write data |
| bus_rdata | output | DATA_W | MCU read data (combinational) |
| ep_flush | input | 1 | Single-cycle flush command |
| rx_end | input | 1 | Completed OUT packet strobe |
| rx_crc_err | input | 1 | Packet had a CRC or bit-stuffing error |
| rx_too_long | input | 1 | Packet exceeded the maximum packet size |
| rx_proto_err | input | 1 | Protocol violation during the transaction |
| dec_valid | output | 1 | Verdict strobe, one cycle after `rx_end` |
| dec_code | output | 2 | Verdict: 0 accept, 1 NAK, 2 STALL, 3 drop |
| stall_req | output | 1 | Level stall request (send-stall bit) |
| fifo_flush | output | 1 | Flush pulse toward the FIFO |

## Verification
The bench uses the default 8-bit address and data widths and places the register at 0x8B. It also reads and writes the neighbouring address 0x8A, which exercises the decoder's rejection path for both reads and writes. Because the width is 8, the two reserved upper bits are present and can be observed staying zero. The directed sequences place packets so that they coincide with write-1 clears and with flushes, and they run the same packet patterns in both modes, so every branch of the verdict priority is reached.

// File: rtl/usb_oep_pkg.sv
package usb_oep_pkg;

    typedef enum logic [1:0] {
        DEC_ACCEPT = 2'd0,
        DEC_NAK    = 2'd1,
        DEC_STALL  = 2'd2,
        DEC_DROP   = 2'd3
    } dec_e;

    localparam int BIT_RDY  = 0;
    localparam int BIT_OVR  = 1;
    localparam int BIT_SSTL = 2;
    localparam int BIT_FSTL = 3;
    localparam int BIT_ISO  = 4;
    localparam int BIT_DERR = 5;
    localparam int NUM_BITS = 6;

    typedef struct packed {
        logic derr;
        logic iso;
        logic fstl;
        logic sstl;
        logic ovr;
        logic rdy;
    } flags_t;

    typedef struct packed {
        logic valid;
        dec_e code;
        logic set_rdy;
        logic set_ovr;
        logic set_fstl;
        logic set_derr;
    } verdict_t;

endpackage

// File: rtl/usb_oep_bus_if.sv
module usb_oep_bus_if #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  CSR_ADDR = 8'h8B
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] csr_word,
    output logic              wr_hit,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(CSR_ADDR);

    logic addr_hit;

    always_comb begin
        addr_hit  = (bus_addr == MATCH);
        wr_hit    = addr_hit && bus_wr;
        wr_data   = wr_hit ? bus_wdata : '0;
        bus_rdata = addr_hit ? csr_word : '0;
    end
endmodule

// File: rtl/usb_oep_decide.sv
module usb_oep_decide
    import usb_oep_pkg::*;
(
    input  logic     rx_end,
    input  logic     rx_crc_err,
    input  logic     rx_too_long,
    input  logic     rx_proto_err,
    input  flags_t   cur,
    output verdict_t verdict
);
    always_comb begin
        verdict       = '0;
        verdict.code  = DEC_ACCEPT;
        verdict.valid = rx_end;
        if (rx_end) begin
            if (cur.sstl) begin
                verdict.code = DEC_STALL;
            end else if (rx_too_long || rx_proto_err) begin
                verdict.code     = DEC_STALL;
                verdict.set_fstl = 1'b1;
            end else if (cur.iso) begin
                if (cur.rdy) begin
                    verdict.code    = DEC_DROP;
                    verdict.set_ovr = 1'b1;
                end else begin
                    verdict.code     = DEC_ACCEPT;
                    verdict.set_rdy  = 1'b1;
                    verdict.set_derr = rx_crc_err;
                end
            end else if (rx_crc_err) begin
                verdict.code = DEC_DROP;
            end else if (cur.rdy) begin
                verdict.code = DEC_NAK;
            end else begin
                verdict.code    = DEC_ACCEPT;
                verdict.set_rdy = 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_oep_flags.sv
module usb_oep_flags
    import usb_oep_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flush,
    input  verdict_t          verdict,
    output flags_t            flags_q
);
    flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        // software side: direct bits and write-one-to-clear bits
        if (wr_hit) begin
            flags_d.sstl = wr_data[BIT_SSTL];
            flags_d.iso  = wr_data[BIT_ISO];
            if (wr_data[BIT_RDY])  flags_d.rdy  = 1'b0;
            if (wr_data[BIT_OVR])  flags_d.ovr  = 1'b0;
            if (wr_data[BIT_FSTL]) flags_d.fstl = 1'b0;
            if (wr_data[BIT_DERR]) flags_d.derr = 1'b0;
        end
        if (flush) flags_d.rdy = 1'b0;
        // hardware events applied last so they win
        if (verdict.set_rdy)  flags_d.rdy  = 1'b1;
        if (verdict.set_ovr)  flags_d.ovr  = 1'b1;
        if (verdict.set_fstl) flags_d.fstl = 1'b1;
        if (verdict.set_derr) flags_d.derr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/usb_out_ep_csr.sv
module usb_out_ep_csr
    import usb_oep_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] CSR_ADDR = 8'h8B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ep_flush,
    input  logic              rx_end,
    input  logic              rx_crc_err,
    input  logic              rx_too_long,
    input  logic              rx_proto_err,
    output logic              dec_valid,
    output logic [1:0]        dec_code,
    output logic              stall_req,
    output logic              fifo_flush
);
    localparam int PAD_W = DATA_W - NUM_BITS;

    typedef struct packed {
        logic valid;
        dec_e code;
        logic flush;
    } out_t;

    flags_t            flags_q;
    verdict_t          verdict;
    logic              wr_hit;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] csr_view;
    out_t              out_d;
    out_t              out_q;

    generate
        if (PAD_W > 0) begin : g_pad
            assign csr_view = {{PAD_W{1'b0}}, flags_q};
        end else begin : g_nopad
            assign csr_view = DATA_W'(flags_q);
        end
    endgenerate

    usb_oep_bus_if #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CSR_ADDR (CSR_ADDR)
    ) u_bus (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .csr_word  (csr_view),
        .wr_hit    (wr_hit),
        .wr_data   (wr_data),
        .bus_rdata (bus_rdata)
    );

    usb_oep_decide u_dec (
        .rx_end       (rx_end),
        .rx_crc_err   (rx_crc_err),
        .rx_too_long  (rx_too_long),
        .rx_proto_err (rx_proto_err),
        .cur          (flags_q),
        .verdict      (verdict)
    );

    usb_oep_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_data (wr_data),
        .flush   (ep_flush),
        .verdict (verdict),
        .flags_q (flags_q)
    );

    always_comb begin
        out_d.valid = verdict.valid;
        out_d.code  = verdict.code;
        out_d.flush = ep_flush;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '{valid: 1'b0, code: DEC_ACCEPT, flush: 1'b0};
        else        out_q <= out_d;
    end

    assign dec_valid  = out_q.valid;
    assign dec_code   = out_q.code;
    assign fifo_flush = out_q.flush;
    assign stall_req  = flags_q.sstl;
endmodule

// File: rtl/usb_oep_chk.sv
module usb_oep_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_end,
    input logic              rx_crc_err,
    input logic              rx_too_long,
    input logic              rx_proto_err,
    input logic              ep_flush,
    input logic              dec_valid,
    input logic [1:0]        dec_code,
    input logic              stall_req,
    input logic              fifo_flush,
    input logic [DATA_W-1:0] csr
);
    // R5
    verdict_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_end |=> dec_valid);

    // R5
    no_spurious_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_end |=> !dec_valid);

    // R11
    stall_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && stall_req) |=> (dec_code == 2'd2));

    // R6
    bulk_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && !stall_req && !rx_too_long && !rx_proto_err && !rx_crc_err
         && !csr[4] && csr[0]) |=> (dec_code == 2'd1));

    // R8
    iso_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && !stall_req && !rx_too_long && !rx_proto_err
         && csr[4] && csr[0]) |=> (dec_code == 2'd3 && csr[1]));

    // R9
    iso_err_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_end && !stall_req && !rx_too_long && !rx_proto_err && rx_crc_err
         && csr[4] && !csr[0]) |=> (dec_code == 2'd0 && csr[0] && csr[5]));

    // R12
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_flush && !rx_end) |=> (!csr[0] && fifo_flush));
endmodule

bind usb_out_ep_csr usb_oep_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_end       (rx_end),
    .rx_crc_err   (rx_crc_err),
    .rx_too_long  (rx_too_long),
    .rx_proto_err (rx_proto_err),
    .ep_flush     (ep_flush),
    .dec_valid    (dec_valid),
    .dec_code     (dec_code),
    .stall_req    (stall_req),
    .fifo_flush   (fifo_flush),
    .csr          (csr_view)
);

// File: tb/usb_out_ep_csr_test.sv
module usb_out_ep_csr_test;
    localparam logic [7:0] REG_A = 8'h8B;
    localparam logic [7:0] OTHER_A = 8'h8A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = REG_A;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ep_flush = 1'b0;
    logic       rx_end = 1'b0;
    logic       rx_crc_err = 1'b0;
    logic       rx_too_long = 1'b0;
    logic       rx_proto_err = 1'b0;
    logic       dec_valid;
    logic [1:0] dec_code;
    logic       stall_req;
    logic       fifo_flush;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    int m_rdy, m_ovr, m_sst, m_fst, m_iso, m_der;
    int e_dv, e_code, e_fl;

    always #2 clk = ~clk;

    usb_out_ep_csr uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_flush(ep_flush),
        .rx_end(rx_end), .rx_crc_err(rx_crc_err), .rx_too_long(rx_too_long),
        .rx_proto_err(rx_proto_err), .dec_valid(dec_valid), .dec_code(dec_code),
        .stall_req(stall_req), .fifo_flush(fifo_flush)
    );

    always @(posedge clk) begin
        int verdict;
        int s_rdy, s_ovr, s_fst, s_der;
        s_rdy = 0; s_ovr = 0; s_fst = 0; s_der = 0; verdict = 0;
        if (!rst_n) begin
            m_rdy = 0; m_ovr = 0; m_sst = 0; m_fst = 0; m_iso = 0; m_der = 0;
            e_dv = 0; e_code = 0; e_fl = 0;
        end else begin
            if (rx_end) begin
                if (m_sst != 0) verdict = 2;
                else if (rx_too_long || rx_proto_err) begin verdict = 2; s_fst = 1; end
                else if (m_iso != 0 && m_rdy != 0) begin verdict = 3; s_ovr = 1; end
                else if (m_iso != 0) begin verdict = 0; s_rdy = 1; s_der = int'(rx_crc_err); end
                else if (rx_crc_err) verdict = 3;
                else if (m_rdy != 0) verdict = 1;
                else begin verdict = 0; s_rdy = 1; end
            end
            if (bus_wr && bus_addr == REG_A) begin
                m_sst = int'(bus_wdata[2]);
                m_iso = int'(bus_wdata[4]);
                if (bus_wdata[0]) m_rdy = 0;
                if (bus_wdata[1]) m_ovr = 0;
                if (bus_wdata[3]) m_fst = 0;
                if (bus_wdata[5]) m_der = 0;
            end
            if (ep_flush) m_rdy = 0;
            if (s_rdy != 0) m_rdy = 1;
            if (s_ovr != 0) m_ovr = 1;
            if (s_fst != 0) m_fst = 1;
            if (s_der != 0) m_der = 1;
            e_dv = int'(rx_end);
            e_code = verdict;
            e_fl = int'(ep_flush);
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_word();
        return (m_der << 5) | (m_iso << 4) | (m_fst << 3) | (m_sst << 2) | (m_ovr << 1) | m_rdy;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
        check("R2 model rdata", int'(bus_rdata), (bus_addr == REG_A) ? model_word() : 0);
        check("R4 model stall_req", int'(stall_req), m_sst);
        check("R5 model dec_valid", int'(dec_valid), e_dv);
        if (e_dv != 0) check("R5 model dec_code", int'(dec_code), e_code);
        check("R12 model fifo_flush", int'(fifo_flush), e_fl);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_addr = REG_A;
        #0;
    endtask

    task automatic pkt(input logic crc, input logic lng, input logic prt);
        rx_end = 1'b1; rx_crc_err = crc; rx_too_long = lng; rx_proto_err = prt;
        step();
        rx_end = 1'b0; rx_crc_err = 1'b0; rx_too_long = 1'b0; rx_proto_err = 1'b0;
    endtask

    initial begin : watchdog
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        #0;
        step();
        // R1 reset state
        check("R1 reset csr", int'(bus_rdata), 8'h00);
        check("R1 reset stall", int'(stall_req), 0);
        check("R1 reset valid", int'(dec_valid), 0);

        // R5 bulk accept
        pkt(1'b0, 1'b0, 1'b0);
        check("R5 accept code", int'(dec_code), 0);
        check("R5 rdy set", int'(bus_rdata), 8'h01);
        step();
        check("R5 single cycle", int'(dec_valid), 0);

        // R6 NAK while packet-ready
        pkt(1'b0, 1'b0, 1'b0);
        check("R6 nak code", int'(dec_code), 1);
        check("R6 no change", int'(bus_rdata), 8'h01);

        // R7 bulk crc error ignored
        pkt(1'b1, 1'b0, 1'b0);
        check("R7 drop code", int'(dec_code), 3);
        check("R7 no change", int'(bus_rdata), 8'h01);

        // R2 other address reads zero; R3 write elsewhere ignored, write 0 ignored
        bus_addr = OTHER_A;
        step();
        check("R2 other addr", int'(bus_rdata), 0);
        wr(OTHER_A, 8'hFF);
        step();
        check("R3 other addr write", int'(bus_rdata), 8'h01);
        wr(REG_A, 8'h00);
        check("R3 write zero", int'(bus_rdata), 8'h01);
        wr(REG_A, 8'h01);
        check("R3 clear rdy", int'(bus_rdata), 8'h00);

        // R4 iso mode, R8 overrun
        wr(REG_A, 8'h10);
        check("R4 iso set", int'(bus_rdata), 8'h10);
        pkt(1'b0, 1'b0, 1'b0);
        pkt(1'b0, 1'b0, 1'b0);
        check("R8 drop code", int'(dec_code), 3);
        check("R8 overrun set", int'(bus_rdata), 8'h13);

        // R13 overrun set while being cleared
        rx_end = 1'b1;
        wr(REG_A, 8'h12);
        rx_end = 1'b0;
        check("R13 set wins", int'(bus_rdata), 8'h13);
        wr(REG_A, 8'h13);
        check("R3 clear both", int'(bus_rdata), 8'h10);

        // R9 iso corrupted packet delivered
        pkt(1'b1, 1'b0, 1'b0);
        check("R9 accept code", int'(dec_code), 0);
        check("R9 derr set", int'(bus_rdata), 8'h31);

        // R12 flush
        ep_flush = 1'b1;
        step();
        ep_flush = 1'b0;
        check("R12 rdy cleared", int'(bus_rdata), 8'h30);
        check("R12 flush pulse", int'(fifo_flush), 1);
        step();
        check("R12 pulse ends", int'(fifo_flush), 0);

        // R13 flush and accept together
        ep_flush = 1'b1;
        pkt(1'b0, 1'b0, 1'b0);
        ep_flush = 1'b0;
        check("R13 flush vs set", int'(bus_rdata), 8'h31);
        wr(REG_A, 8'h21);
        check("R8 back to bulk", int'(bus_rdata), 8'h00);

        // R10 length and protocol faults
        pkt(1'b0, 1'b1, 1'b0);
        check("R10 long stall", int'(dec_code), 2);
        check("R10 fstl set", int'(bus_rdata), 8'h08);
        wr(REG_A, 8'h18);
        pkt(1'b0, 1'b0, 1'b1);
        check("R10 proto stall", int'(dec_code), 2);
        check("R10 fstl iso", int'(bus_rdata), 8'h18);
        wr(REG_A, 8'h08);

        // R11 send-stall overrides everything
        wr(REG_A, 8'h04);
        check("R4 stall_req", int'(stall_req), 1);
        pkt(1'b0, 1'b0, 1'b0);
        check("R11 stall code", int'(dec_code), 2);
        pkt(1'b0, 1'b1, 1'b0);
        check("R11 no flags", int'(bus_rdata), 8'h04);
        wr(REG_A, 8'h00);
        check("R4 stall off", int'(stall_req), 0);

        // R8 no overrun in bulk mode
        pkt(1'b0, 1'b0, 1'b0);
        pkt(1'b1, 1'b0, 1'b0);
        check("R8 bulk no ovr", int'(bus_rdata), 8'h01);

        repeat (2) step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule